// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

This block collects level-sensitive interrupt requests from devices and presents them to a processor as two interrupt lines. Requests arrive in three byte-wide groups: two local groups, each feeding one processor line, and a third mappable group. The mappable group is qualified by two independent mask bytes. Whatever survives the first mask is folded into one fixed bit of local group 0, and whatever survives the second mask is folded into one fixed bit of local group 1. This gives eight further sources behind each local group without widening either local byte.

All request inputs pass through a two-flop synchronizer before they reach a status register. Software talks to the block through a synchronous byte-wide port with separate read and write strobes. Through this port it reads the three status bytes and reads or writes the four mask bytes. Masks read back what was last written, so a driver can enable one source with a read-modify-write. Writing zero to all four masks silences every source.

Top module: `irqc_cascade`

## Requirements
- R1: After reset all four mask registers read 0x00 and both processor lines are low.
- R2: Mask registers sit at byte addresses 0x1 (local group 0), 0x3 (local group 1), 0x5 (mappable mask 0) and 0x9 (mappable mask 1, four above mask 0). Each reads back its last written value with no effect on the other three. Read data appears on `rd_data` in the cycle after `rd_en` is sampled high.
- R3: Status registers at 0x0 (local group 0), 0x2 (local group 1) and 0x4 (mappable group) are read-only, and writes to them change nothing. Every other address reads 0x00.
- R4: A request input change reaches the status registers and the processor lines after exactly two rising clock edges, and not after one.
- R5: Processor line 0 is high exactly when some bit of (local group 0 status AND its mask) is 1. Processor line 1 follows the same rule for local group 1.
- R6: Local group 0 status bit 7 is the OR of request input 7 of that group and "any bit of (mappable status AND mappable mask 0) is 1".
- R7: Local group 1 status bit 3 is the OR of request input 3 of that group and "any bit of (mappable status AND mappable mask 1) is 1".
- R8: Mappable mask 0 has no effect on local group 1 or on processor line 1, and mappable mask 1 has no effect on local group 0 or on processor line 0.
- R9: With all four masks written to zero, both processor lines stay low for any request input pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_l0_i | input | 8 | Request inputs of local group 0 (sources 0 to 7) |
| irq_l1_i | input | 8 | Request inputs of local group 1 (sources 8 to 15) |
| irq_map_i | input | 8 | Request inputs of the mappable group |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after a read strobe |
| cpu_irq0_o | output | 1 | Processor interrupt line of local group 0 |
| cpu_irq1_o | output | 1 | Processor interrupt line of local group 1 |

## Verification
Each mask is swept over all 256 values with write and read-back. Each local group is then driven with 256 status and mask pairs generated by different linear formulas, which separates a correct AND-reduce from OR, XOR or wrong-bit variants. Each mappable mask is swept over all 256 values against a varying mappable pattern, with the other side watched to tell the two fold paths apart and to catch a fold into the wrong group or bit. A single-bit step on an input, sampled after one edge and after two, pins the synchronizer depth. A final pass with every input high and the masks zeroed in stages confirms that the masks silence every source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register byte addresses
  localparam int unsigned A_L0_STAT   = 0;
  localparam int unsigned A_L0_MASK   = 1;
  localparam int unsigned A_L1_STAT   = 2;
  localparam int unsigned A_L1_MASK   = 3;
  localparam int unsigned A_MAP_STAT  = 4;
  localparam int unsigned A_MAP_MASK0 = 5;
  localparam int unsigned A_MAP_MASK1 = A_MAP_MASK0 + 4;

  // Local bit positions that carry the folded mappable results
  localparam int unsigned FOLD0_BIT = 7;
  localparam int unsigned FOLD1_BIT = 3;

  // Index of each mask inside the mask bank
  localparam int unsigned NUM_MASKS = 4;
  localparam int unsigned MI_L0 = 0;
  localparam int unsigned MI_L1 = 1;
  localparam int unsigned MI_M0 = 2;
  localparam int unsigned MI_M1 = 3;

  function automatic int unsigned mask_addr(input int unsigned idx);
    case (idx)
      MI_L0:   mask_addr = A_L0_MASK;
      MI_L1:   mask_addr = A_L1_MASK;
      MI_M0:   mask_addr = A_MAP_MASK0;
      default: mask_addr = A_MAP_MASK1;
    endcase
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;
  logic [1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned GRP_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GRP_W-1:0]  wr_data,
  input  logic [GRP_W-1:0]  stat_l0,
  input  logic [GRP_W-1:0]  stat_l1,
  input  logic [GRP_W-1:0]  stat_m,
  output logic [GRP_W-1:0]  mask_l0,
  output logic [GRP_W-1:0]  mask_l1,
  output logic [GRP_W-1:0]  mask_m0,
  output logic [GRP_W-1:0]  mask_m1,
  output logic [GRP_W-1:0]  rd_data
);
  localparam logic [ADDR_W-1:0] AD_L0S = ADDR_W'(A_L0_STAT);
  localparam logic [ADDR_W-1:0] AD_L1S = ADDR_W'(A_L1_STAT);
  localparam logic [ADDR_W-1:0] AD_MS  = ADDR_W'(A_MAP_STAT);

  logic [NUM_MASKS-1:0][GRP_W-1:0] mask_q;
  logic [NUM_MASKS-1:0][GRP_W-1:0] mask_d;
  logic [NUM_MASKS-1:0]            mask_hit;
  logic [GRP_W-1:0]                rd_mux;
  logic [GRP_W-1:0]                rd_q;
  logic [GRP_W-1:0]                rd_d;

  // Per-mask write decode
  for (genvar i = 0; i < NUM_MASKS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(mask_addr(i));
    assign mask_hit[i] = wr_en && (addr == MY_ADDR);
  end

  always_comb begin
    for (int i = 0; i < NUM_MASKS; i++) begin
      mask_d[i] = mask_hit[i] ? wr_data : mask_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // Read select: status bytes, mask bytes, zero elsewhere
  always_comb begin
    rd_mux = '0;
    if (addr == AD_L0S) rd_mux = stat_l0;
    if (addr == AD_L1S) rd_mux = stat_l1;
    if (addr == AD_MS)  rd_mux = stat_m;
    for (int i = 0; i < NUM_MASKS; i++) begin
      if (addr == ADDR_W'(mask_addr(i))) rd_mux = mask_q[i];
    end
  end

  always_comb begin
    rd_d = rd_en ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign mask_l0 = mask_q[MI_L0];
  assign mask_l1 = mask_q[MI_L1];
  assign mask_m0 = mask_q[MI_M0];
  assign mask_m1 = mask_q[MI_M1];
  assign rd_data = rd_q;
endmodule

// File: rtl/irqc_fold.sv
module irqc_fold
  import irqc_pkg::*;
#(
  parameter int unsigned GRP_W = 8
) (
  input  logic [GRP_W-1:0] raw_l0,
  input  logic [GRP_W-1:0] raw_l1,
  input  logic [GRP_W-1:0] stat_m,
  input  logic [GRP_W-1:0] mask_l0,
  input  logic [GRP_W-1:0] mask_l1,
  input  logic [GRP_W-1:0] mask_m0,
  input  logic [GRP_W-1:0] mask_m1,
  output logic [GRP_W-1:0] stat_l0,
  output logic [GRP_W-1:0] stat_l1,
  output logic             cpu0,
  output logic             cpu1
);
  localparam int unsigned NGRP = 2;

  logic [NGRP-1:0][GRP_W-1:0] mmask;
  logic [NGRP-1:0][GRP_W-1:0] raw;
  logic [NGRP-1:0][GRP_W-1:0] lmask;
  logic [NGRP-1:0][GRP_W-1:0] lstat;
  logic [NGRP-1:0]            map_any;
  logic [NGRP-1:0]            line;

  assign mmask = {mask_m1, mask_m0};
  assign raw   = {raw_l1, raw_l0};
  assign lmask = {mask_l1, mask_l0};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned FBIT = (g == 0) ? FOLD0_BIT : FOLD1_BIT;
    logic [GRP_W-1:0] fold_vec;
    assign map_any[g] = |(stat_m & mmask[g]);
    assign fold_vec   = GRP_W'(map_any[g]) << FBIT;
    assign lstat[g]   = raw[g] | fold_vec;
    assign line[g]    = |(lstat[g] & lmask[g]);
  end

  assign stat_l0 = lstat[0];
  assign stat_l1 = lstat[1];
  assign cpu0    = line[0];
  assign cpu1    = line[1];
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade #(
  parameter int unsigned GRP_W       = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  irq_l0_i,
  input  logic [GRP_W-1:0]  irq_l1_i,
  input  logic [GRP_W-1:0]  irq_map_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GRP_W-1:0]  wr_data,
  output logic [GRP_W-1:0]  rd_data,
  output logic              cpu_irq0_o,
  output logic              cpu_irq1_o
);
  localparam int unsigned SYNC_W = 3 * GRP_W;

  logic              rst_q_n;
  logic [SYNC_W-1:0] sync_out;
  logic [GRP_W-1:0]  raw_l0, raw_l1, stat_m;
  logic [GRP_W-1:0]  stat_l0, stat_l1;
  logic [GRP_W-1:0]  mask_l0, mask_l1, mask_m0, mask_m1;

  irqc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  irqc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .din   ({irq_map_i, irq_l1_i, irq_l0_i}),
    .dout  (sync_out)
  );

  assign raw_l0 = sync_out[GRP_W-1:0];
  assign raw_l1 = sync_out[2*GRP_W-1:GRP_W];
  assign stat_m = sync_out[3*GRP_W-1:2*GRP_W];

  irqc_fold #(.GRP_W(GRP_W)) u_fold (
    .raw_l0  (raw_l0),
    .raw_l1  (raw_l1),
    .stat_m  (stat_m),
    .mask_l0 (mask_l0),
    .mask_l1 (mask_l1),
    .mask_m0 (mask_m0),
    .mask_m1 (mask_m1),
    .stat_l0 (stat_l0),
    .stat_l1 (stat_l1),
    .cpu0    (cpu_irq0_o),
    .cpu1    (cpu_irq1_o)
  );

  irqc_regs #(.GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .stat_l0 (stat_l0),
    .stat_l1 (stat_l1),
    .stat_m  (stat_m),
    .mask_l0 (mask_l0),
    .mask_l1 (mask_l1),
    .mask_m0 (mask_m0),
    .mask_m1 (mask_m1),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/irqc_cascade_chk.sv
module irqc_cascade_chk
  import irqc_pkg::*;
#(
  parameter int unsigned GRP_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [GRP_W-1:0]  wr_data,
  input logic [GRP_W-1:0]  rd_data,
  input logic [GRP_W-1:0]  irq_map_i,
  input logic [GRP_W-1:0]  stat_m,
  input logic [GRP_W-1:0]  mask_l0,
  input logic [GRP_W-1:0]  mask_l1,
  input logic [GRP_W-1:0]  mask_m0,
  input logic [GRP_W-1:0]  mask_m1,
  input logic              cpu_irq0_o,
  input logic              cpu_irq1_o
);
  localparam logic [ADDR_W-1:0] AD_M1 = ADDR_W'(A_MAP_MASK1);
  localparam logic [ADDR_W-1:0] AD_MS = ADDR_W'(A_MAP_STAT);

  logic [1:0] age_q;
  logic [1:0] age_d;
  logic       ready;

  always_comb begin
    age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) age_q <= 2'd0;
    else          age_q <= age_d;
  end

  assign ready = (age_q == 2'd2);

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_en |=> ($stable(mask_l0) && $stable(mask_l1) && $stable(mask_m0) && $stable(mask_m1))); // R2

  AST_MASK1_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && addr == AD_M1) |=> (mask_m1 == $past(wr_data))); // R2

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && addr == AD_MS) |=> (rd_data == $past(stat_m))); // R3

  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_q_n)
    ready |-> (stat_m == $past(irq_map_i, 2))); // R4

  AST_LINE0_GATED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mask_l0 == '0) |-> !cpu_irq0_o); // R9

  AST_LINE1_GATED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mask_l1 == '0) |-> !cpu_irq1_o); // R9

  AST_FOLD0_REACH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mask_l0[FOLD0_BIT] && ((stat_m & mask_m0) != '0)) |-> cpu_irq0_o); // R6

  AST_FOLD1_REACH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mask_l1[FOLD1_BIT] && ((stat_m & mask_m1) != '0)) |-> cpu_irq1_o); // R7
endmodule

bind irqc_cascade irqc_cascade_chk #(.GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .irq_map_i  (irq_map_i),
  .stat_m     (stat_m),
  .mask_l0    (mask_l0),
  .mask_l1    (mask_l1),
  .mask_m0    (mask_m0),
  .mask_m1    (mask_m1),
  .cpu_irq0_o (cpu_irq0_o),
  .cpu_irq1_o (cpu_irq1_o)
);

// File: tb/test_irqc_cascade.sv
`timescale 1ns/1ps
module test_irqc_cascade;
  logic       clk;
  logic       rst_n;
  logic [7:0] irq_l0_i, irq_l1_i, irq_map_i;
  logic       wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       cpu_irq0_o, cpu_irq1_o;

  int n_chk = 0;
  int n_err = 0;

  irqc_cascade i_irqc_cascade (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_l0_i   (irq_l0_i),
    .irq_l1_i   (irq_l1_i),
    .irq_map_i  (irq_map_i),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .cpu_irq0_o (cpu_irq0_o),
    .cpu_irq1_o (cpu_irq1_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = 4'(a); wr_data = 8'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_en = 1'b1; addr = 4'(a);
    @(posedge clk); @(negedge clk);
    d = int'(rd_data);
    rd_en = 1'b0;
  endtask

  task automatic drive(input int l0, input int l1, input int mp);
    irq_l0_i = 8'(l0); irq_l1_i = 8'(l1); irq_map_i = 8'(mp);
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  function automatic int st0(input int l0, input int mp, input int m0);
    return (l0 | ((((mp & m0) & 255) != 0) ? 8'h80 : 0)) & 255;
  endfunction
  function automatic int st1(input int l1, input int mp, input int m1);
    return (l1 | ((((mp & m1) & 255) != 0) ? 8'h08 : 0)) & 255;
  endfunction
  function automatic int any8(input int v);
    return ((v & 255) != 0) ? 1 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int d;
    int maddr [4];
    maddr[0] = 1; maddr[1] = 3; maddr[2] = 5; maddr[3] = 9;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    irq_l0_i = '0; irq_l1_i = '0; irq_map_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(maddr[i], d);
      check("R1 mask reset", d, 0);
    end
    check("R1 line0 reset", int'(cpu_irq0_o), 0);
    check("R1 line1 reset", int'(cpu_irq1_o), 0);

    // R2 read-back sweep of every mask
    for (int i = 0; i < 4; i++) begin
      for (int v = 0; v < 256; v++) begin
        wr(maddr[i], v);
        rd(maddr[i], d);
        check("R2 mask readback", d, v);
      end
    end
    wr(1, 8'h11); wr(3, 8'h22); wr(5, 8'h44); wr(9, 8'h88);
    rd(1, d); check("R2 l0 mask isolated", d, 8'h11);
    rd(3, d); check("R2 l1 mask isolated", d, 8'h22);
    rd(5, d); check("R2 map mask0 isolated", d, 8'h44);
    rd(9, d); check("R2 map mask1 isolated", d, 8'h88);
    wr(1, 0); wr(3, 0); wr(5, 0); wr(9, 0);

    // R3 status read-only, unused addresses read zero
    drive(8'h5A, 8'hC3, 8'h0F);
    wr(0, 8'hFF); wr(2, 8'h00); wr(4, 8'hF0);
    rd(0, d); check("R3 l0 status", d, 8'h5A);
    rd(2, d); check("R3 l1 status", d, 8'hC3);
    rd(4, d); check("R3 map status", d, 8'h0F);
    for (int a = 0; a < 16; a++) begin
      if (a == 6 || a == 7 || a == 8 || a > 9) begin
        wr(a, 8'hA5);
        rd(a, d);
        check("R3 unused reads zero", d, 0);
      end
    end
    rd(1, d); check("R3 write to status leaves mask", d, 0);

    // R4 two-edge synchronizer latency
    drive(0, 0, 0);
    wr(1, 8'h01);
    irq_l0_i = 8'h01;
    @(posedge clk); @(negedge clk);
    check("R4 not after one edge", int'(cpu_irq0_o), 0);
    @(posedge clk); @(negedge clk);
    check("R4 after two edges", int'(cpu_irq0_o), 1);
    irq_l0_i = 8'h00;
    @(posedge clk); @(negedge clk);
    check("R4 release not after one edge", int'(cpu_irq0_o), 1);
    @(posedge clk); @(negedge clk);
    check("R4 release after two edges", int'(cpu_irq0_o), 0);

    // R5 local pending sweep, map masks zero
    for (int m = 0; m < 256; m++) begin
      int s0, s1, m1;
      s0 = (m * 37 + 11) & 255;
      s1 = (m * 91 + 5) & 255;
      m1 = (m * 13 + 200) & 255;
      wr(1, m); wr(3, m1);
      drive(s0, s1, 8'hFF);
      check("R5 line0", int'(cpu_irq0_o), any8(s0 & m));
      check("R5 line1", int'(cpu_irq1_o), any8(s1 & m1));
    end

    // R6 fold of map mask0 into group 0 bit 7; R8 no reach into group 1
    wr(1, 8'h80); wr(3, 8'hFF); wr(9, 0);
    for (int m0 = 0; m0 < 256; m0++) begin
      int mp;
      mp = (m0 * 53 + 7) & 255;
      wr(5, m0);
      drive(0, 0, mp);
      check("R6 line0 from fold", int'(cpu_irq0_o), any8(mp & m0));
      check("R8 mask0 off line1", int'(cpu_irq1_o), 0);
      if (m0 % 16 == 3) begin
        rd(0, d); check("R6 l0 status bit7", d, st0(0, mp, m0));
        rd(2, d); check("R8 l1 status untouched", d, 0);
      end
    end
    drive(8'h80, 0, 0);
    rd(0, d); check("R6 input bit7 alone", d, 8'h80);

    // R7 fold of map mask1 into group 1 bit 3; R8 no reach into group 0
    wr(5, 0); wr(1, 8'hFF); wr(3, 8'h08);
    for (int m1 = 0; m1 < 256; m1++) begin
      int mp;
      mp = (m1 * 29 + 101) & 255;
      wr(9, m1);
      drive(0, 0, mp);
      check("R7 line1 from fold", int'(cpu_irq1_o), any8(mp & m1));
      check("R8 mask1 off line0", int'(cpu_irq0_o), 0);
      if (m1 % 16 == 9) begin
        rd(2, d); check("R7 l1 status bit3", d, st1(0, mp, m1));
        rd(0, d); check("R8 l0 status untouched", d, 0);
      end
    end

    // R9 zeroing masks silences everything
    wr(1, 8'hFF); wr(3, 8'hFF); wr(5, 8'hFF); wr(9, 8'hFF);
    drive(8'hFF, 8'hFF, 8'hFF);
    check("R9 line0 on before", int'(cpu_irq0_o), 1);
    check("R9 line1 on before", int'(cpu_irq1_o), 1);
    wr(1, 0); wr(3, 0);
    @(negedge clk);
    check("R9 line0 off local zero", int'(cpu_irq0_o), 0);
    check("R9 line1 off local zero", int'(cpu_irq1_o), 0);
    wr(5, 0); wr(9, 0);
    for (int p = 0; p < 8; p++) begin
      drive((p * 45) & 255, (p * 77 + 1) & 255, 8'hFF);
      check("R9 line0 off all zero", int'(cpu_irq0_o), 0);
      check("R9 line1 off all zero", int'(cpu_irq1_o), 0);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule